// File: doc/BRIEF.md
# SPI Serial Memory Slave Engine

This block is the slave side of a byte-wide serial memory reached over SPI in mode 0 or mode 3. A host selects it by pulling chip select low and clocks in a one-byte command, then a 16-bit address where one is needed. It then either receives data into a page buffer or streams array contents back on the serial output. All four SPI inputs are brought into the system clock through two-flop synchronisers. Edges are detected in that clock domain, so the system clock must run at least eight times faster than the serial clock.

Writes are staged in a page buffer and committed by a self-timed write cycle. That cycle is a counter of `WC_CYCLES` system clocks, and it copies the staged bytes into a synchronous on-chip array. Before a cycle starts, the engine raises a request to an external protection unit carrying the page number and a status flag. The protection unit grants or refuses it in the same cycle. A status-register write is not stored here: it is handed to the protection unit as a one-cycle pulse with its data byte. A hold input freezes a transfer partway through. The output enable stays low whenever the output pin must float.

Top module: `spi_mem_slave`

## Requirements
- R1: After reset, `spi_miso_oe` and `busy` are 0. The output enable is high only while a read or status-read command is shifting out data.
- R2: A command byte has the form 0000_x_ccc, and bit 3 is ignored. The command codes are: ccc=110 sets the write-enable latch, 100 clears it, 101 reads status, 001 writes status, 011 reads the array and 010 writes the array. The status byte is {prot_status[5:0], latch, 0} when idle.
- R3: Any other command byte keeps `spi_miso_oe` low and ignores further input until chip select falls again. A later command then works normally.
- R4: A read takes a 16-bit address, MSB first, of which only the low `AW` bits count. It returns bytes MSB first from consecutive addresses, and after the top address it continues at address 0.
- R5: A write or status-write command issued while the write-enable latch is clear is ignored, so no write cycle starts and the array is unchanged.
- R6: A write cycle starts only when chip select rises after a whole number of data bits, at least one byte, and `wreq_allow` is 1. A rise partway through a byte, or a refused request, leaves the array unchanged and `busy` low.
- R7: During a write, only the low 6 address bits advance after each data byte. Bytes past the end of a 64-byte page wrap to its start and overwrite earlier bytes.
- R8: `busy` stays high for exactly `WC_CYCLES` system clocks, and the write-enable latch is clear when `busy` falls.
- R9: While `busy` is high, every command except status read is ignored and no request is raised. A status read returns 0xFF.
- R10: A granted status write produces a one-clock `stat_wr_valid` pulse carrying the last received data byte, and also runs a write cycle.
- R11: Hold low, while the serial clock is low, floats the output and freezes the bit position. Hold high, while the serial clock is low, resumes the transfer with no bit lost.
- R12: Every function above behaves identically in mode 0 (clock idles low) and mode 3 (clock idles high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock |
| spi_mosi | input | 1 | Serial data in |
| spi_hold_n | input | 1 | Pause input, active low |
| spi_miso | output | 1 | Serial data out value |
| spi_miso_oe | output | 1 | Drive enable for the serial output pad |
| busy | output | 1 | Self-timed write cycle in progress |
| wreq_valid | output | 1 | Request to start a write cycle |
| wreq_is_status | output | 1 | Request is a status write, not an array write |
| wreq_page | output | AW-6 | Page addressed by the request |
| wreq_allow | input | 1 | Protection unit grants the request (same cycle) |
| prot_status | input | 6 | Protection bits reported in status bits 7..2 |
| stat_wr_valid | output | 1 | One-cycle pulse carrying a granted status write |
| stat_wr_data | output | 8 | Data byte of that status write |

## Verification
The assertions assume that chip select, the serial clock and hold change no faster than a few system clocks apart. They also assume that `wreq_allow` is a same-cycle combinational answer. The bench drives every serial line from the falling system-clock edge and holds each serial clock phase for eight system clocks. It changes hold only while the serial clock is low, and computes `wreq_allow` combinationally from `wreq_page`. Chip select rises only while the serial clock is at its mode's rest level, or mid-byte when testing abandonment.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_OP    = 3'd1,
        ST_ADDR  = 3'd2,
        ST_RD    = 3'd3,
        ST_RDSR  = 3'd4,
        ST_WDATA = 3'd5,
        ST_WRSR  = 3'd6,
        ST_SKIP  = 3'd7
    } phase_t;

    localparam logic [2:0] CMD_SETWE = 3'b110;
    localparam logic [2:0] CMD_CLRWE = 3'b100;
    localparam logic [2:0] CMD_RDST  = 3'b101;
    localparam logic [2:0] CMD_WRST  = 3'b001;
    localparam logic [2:0] CMD_RDMEM = 3'b011;
    localparam logic [2:0] CMD_WRMEM = 3'b010;

    typedef struct packed {
        logic sck_rise;
        logic sck_fall;
        logic cs_rise;
        logic cs_fall;
        logic sck_lvl;
        logic mosi;
        logic hold_n;
    } spi_ev_t;

    function automatic logic [7:0] status_word(input logic busy, input logic wel,
                                               input logic [5:0] prot);
        return busy ? 8'hFF : {prot, wel, 1'b0};
    endfunction

endpackage

// File: rtl/spi_mem_sync.sv
module spi_mem_sync
    import spi_mem_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [3:0]    raw,      // {hold_n, cs_n, mosi, sck}
    output spi_ev_t       ev
);
    localparam logic [3:0] REST = 4'b1100;

    logic [3:0] lvl;
    logic       sck_d, cs_d;

    for (genvar i = 0; i < 4; i++) begin : g_bit
        logic [1:0] pipe;
        always_ff @(posedge clk) begin
            if (rst) pipe <= {2{REST[i]}};
            else     pipe <= {pipe[0], raw[i]};
        end
        assign lvl[i] = pipe[1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_d <= REST[0];
            cs_d  <= REST[2];
        end else begin
            sck_d <= lvl[0];
            cs_d  <= lvl[2];
        end
    end

    assign ev.sck_rise = lvl[0] & ~sck_d;
    assign ev.sck_fall = ~lvl[0] & sck_d;
    assign ev.cs_rise  = lvl[2] & ~cs_d;
    assign ev.cs_fall  = ~lvl[2] & cs_d;
    assign ev.sck_lvl  = lvl[0];
    assign ev.mosi     = lvl[1];
    assign ev.hold_n   = lvl[3];
endmodule

// File: rtl/spi_mem_array.sv
module spi_mem_array #(
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
        rdata <= cells[raddr];
    end
endmodule

// File: rtl/spi_mem_pagebuf.sv
module spi_mem_pagebuf #(
    parameter int PW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          we,
    input  logic [PW-1:0] wptr,
    input  logic [7:0]    wdata,
    input  logic [PW-1:0] rptr,
    output logic [7:0]    rdata,
    output logic          rvalid
);
    localparam int PAGE = 1 << PW;

    logic [7:0]      slot [PAGE];
    logic [PAGE-1:0] filled;

    always_ff @(posedge clk) begin
        if (rst || clr)  filled <= '0;
        else if (we)     filled[wptr] <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (we) slot[wptr] <= wdata;
    end

    assign rdata  = slot[rptr];
    assign rvalid = filled[rptr];
endmodule

// File: rtl/spi_mem_slave.sv
module spi_mem_slave
    import spi_mem_pkg::*;
#(
    parameter int AW        = 11,
    parameter int PW        = 6,
    parameter int WC_CYCLES = 500
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             spi_cs_n,
    input  logic             spi_sck,
    input  logic             spi_mosi,
    input  logic             spi_hold_n,
    output logic             spi_miso,
    output logic             spi_miso_oe,
    output logic             busy,
    output logic             wreq_valid,
    output logic             wreq_is_status,
    output logic [AW-PW-1:0] wreq_page,
    input  logic             wreq_allow,
    input  logic [5:0]       prot_status,
    output logic             stat_wr_valid,
    output logic [7:0]       stat_wr_data
);
    localparam int PAGE   = 1 << PW;
    localparam int WC_EFF = (WC_CYCLES < PAGE) ? PAGE : WC_CYCLES;
    localparam int CW     = $clog2(WC_EFF);

    spi_ev_t ev;
    phase_t  ph;
    logic [2:0]       bitcnt;
    logic [6:0]       sh;
    logic [7:0]       tx, sr_data, arr_q, pb_q;
    logic             is_rd, abyte, have_data, out_live, hold_eff, wel, copying, pb_vld;
    logic [AW-1:0]    addr_acc, rd_addr;
    logic [PW-1:0]    wptr, cp_idx;
    logic [AW-PW-1:0] page;
    logic [CW-1:0]    wcnt;

    spi_mem_sync u_sync (
        .clk(clk), .rst(rst),
        .raw({spi_hold_n, spi_cs_n, spi_mosi, spi_sck}),
        .ev(ev)
    );

    wire        step     = (ph != ST_IDLE) && !hold_eff && !ev.cs_rise && !ev.cs_fall;
    wire        rise_ev  = step && ev.sck_rise;
    wire        byte_end = rise_ev && (bitcnt == 3'd7);
    wire [7:0]  byte_in  = {sh, ev.mosi};
    wire        cmd_ok   = (byte_in[7:4] == 4'b0000);
    wire [AW-1:0] full_addr = addr_acc | AW'(byte_in);

    assign wreq_valid     = ev.cs_rise && (bitcnt == 3'd0) && have_data &&
                            (ph == ST_WDATA || ph == ST_WRSR);
    assign wreq_is_status = (ph == ST_WRSR);
    assign wreq_page      = page;

    wire pb_clr = byte_end && ph == ST_ADDR && abyte && !is_rd;
    wire pb_we  = byte_end && ph == ST_WDATA;

    spi_mem_pagebuf #(.PW(PW)) u_pbuf (
        .clk(clk), .rst(rst), .clr(pb_clr), .we(pb_we), .wptr(wptr),
        .wdata(byte_in), .rptr(cp_idx), .rdata(pb_q), .rvalid(pb_vld)
    );

    spi_mem_array #(.AW(AW)) u_arr (
        .clk(clk), .we(copying && pb_vld), .waddr({page, cp_idx}),
        .wdata(pb_q), .raddr(rd_addr), .rdata(arr_q)
    );

    assign spi_miso    = tx[7];
    assign spi_miso_oe = out_live && !hold_eff && (ph == ST_RD || ph == ST_RDSR);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph <= ST_IDLE;  bitcnt <= '0;  sh <= '0;  tx <= '0;
            is_rd <= 1'b0;  abyte <= 1'b0;  have_data <= 1'b0;  out_live <= 1'b0;
            hold_eff <= 1'b0;  wel <= 1'b0;  busy <= 1'b0;  copying <= 1'b0;
            addr_acc <= '0;  rd_addr <= '0;  wptr <= '0;  cp_idx <= '0;  page <= '0;
            wcnt <= '0;  sr_data <= '0;  stat_wr_valid <= 1'b0;  stat_wr_data <= '0;
        end else begin
            stat_wr_valid <= 1'b0;

            if (ph == ST_IDLE)   hold_eff <= 1'b0;
            else if (!ev.sck_lvl) hold_eff <= !ev.hold_n;

            if (busy) begin
                if (copying) begin
                    cp_idx <= cp_idx + 1'b1;
                    if (&cp_idx) copying <= 1'b0;
                end
                if (wcnt == '0) begin
                    busy <= 1'b0;
                    wel  <= 1'b0;
                end else begin
                    wcnt <= wcnt - 1'b1;
                end
            end

            if (ev.cs_fall) begin
                ph <= ST_OP;  bitcnt <= '0;  abyte <= 1'b0;
                have_data <= 1'b0;  out_live <= 1'b0;
            end else if (ev.cs_rise) begin
                ph <= ST_IDLE;  out_live <= 1'b0;
                if (wreq_valid && wreq_allow) begin
                    busy <= 1'b1;  wcnt <= CW'(WC_EFF - 1);
                    copying <= !wreq_is_status;  cp_idx <= '0;
                    stat_wr_valid <= wreq_is_status;  stat_wr_data <= sr_data;
                end
            end

            if (rise_ev) begin
                sh <= byte_in[6:0];
                bitcnt <= bitcnt + 1'b1;
            end

            if (byte_end) begin
                unique case (ph)
                    ST_OP: begin
                        ph <= ST_SKIP;
                        if (cmd_ok && busy) begin
                            if (byte_in[2:0] == CMD_RDST) ph <= ST_RDSR;
                        end else if (cmd_ok) begin
                            unique case (byte_in[2:0])
                                CMD_SETWE: wel <= 1'b1;
                                CMD_CLRWE: wel <= 1'b0;
                                CMD_RDST:  ph  <= ST_RDSR;
                                CMD_WRST:  if (wel) ph <= ST_WRSR;
                                CMD_RDMEM: begin ph <= ST_ADDR; is_rd <= 1'b1; end
                                CMD_WRMEM: if (wel) begin ph <= ST_ADDR; is_rd <= 1'b0; end
                                default:   ph <= ST_SKIP;
                            endcase
                        end
                    end
                    ST_ADDR: begin
                        if (!abyte) begin
                            addr_acc <= AW'({byte_in, 8'h00});
                            abyte <= 1'b1;
                        end else begin
                            rd_addr <= full_addr;
                            wptr    <= full_addr[PW-1:0];
                            page    <= full_addr[AW-1:PW];
                            ph      <= is_rd ? ST_RD : ST_WDATA;
                        end
                    end
                    ST_WDATA: begin
                        wptr <= wptr + 1'b1;
                        have_data <= 1'b1;
                    end
                    ST_WRSR: begin
                        sr_data <= byte_in;
                        have_data <= 1'b1;
                    end
                    default: ;
                endcase
            end

            if (step && ev.sck_fall && (ph == ST_RD || ph == ST_RDSR)) begin
                if (bitcnt == 3'd0) begin
                    tx <= (ph == ST_RD) ? arr_q : status_word(busy, wel, prot_status);
                    out_live <= 1'b1;
                    if (ph == ST_RD) rd_addr <= rd_addr + 1'b1;
                end else begin
                    tx <= {tx[6:0], 1'b0};
                end
            end
        end
    end
endmodule

// File: rtl/spi_mem_slave_chk.sv
module spi_mem_slave_chk
    import spi_mem_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       busy,
    input logic       wel,
    input logic       miso_oe,
    input logic       wreq_valid,
    input logic       wreq_allow,
    input logic       hold_eff,
    input logic [2:0] bitcnt,
    input logic [2:0] ph
);
    a_r1_oe_only_output_phase: assert property (@(posedge clk) disable iff (rst)
        miso_oe |-> (ph == 3'(ST_RD) || ph == 3'(ST_RDSR)));

    a_r6_cycle_needs_grant: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(wreq_valid && wreq_allow));

    a_r8_latch_clear_at_end: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> !wel);

    a_r9_no_request_while_busy: assert property (@(posedge clk) disable iff (rst)
        busy |-> !wreq_valid);

    a_r11_hold_floats_output: assert property (@(posedge clk) disable iff (rst)
        hold_eff |-> !miso_oe);

    a_r11_hold_freezes_position: assert property (@(posedge clk) disable iff (rst)
        hold_eff |=> $stable(bitcnt));
endmodule

bind spi_mem_slave spi_mem_slave_chk u_chk (
    .clk(clk), .rst(rst), .busy(busy), .wel(wel), .miso_oe(spi_miso_oe),
    .wreq_valid(wreq_valid), .wreq_allow(wreq_allow), .hold_eff(hold_eff),
    .bitcnt(bitcnt), .ph(ph)
);

// File: tb/tb_spi_mem_slave.sv
module tb_spi_mem_slave;
    localparam int AW   = 11;
    localparam int PW   = 6;
    localparam int WC   = 1000;
    localparam int HALF = 8;
    localparam logic [AW-PW-1:0] DENY_PAGE = 5'd12;   // address 0x300
    localparam logic [23:0] VEC [6] = '{
        24'h0000_5A, 24'h07FF_C3, 24'hF805_3C,
        24'h00C0_33, 24'h0300_11, 24'h0421_E7
    };

    logic clk = 1'b0, rst = 1'b1;
    logic cs_n = 1'b1, sck = 1'b0, mosi = 1'b0, hold_n = 1'b1;
    logic spi_miso, spi_miso_oe, busy, wreq_valid, wreq_is_status, stat_wr_valid;
    logic [AW-PW-1:0] wreq_page;
    logic [7:0] stat_wr_data;
    logic deny_on = 1'b0;
    wire  wreq_allow = !(deny_on && wreq_page == DENY_PAGE);

    always #5 clk = ~clk;

    spi_mem_slave #(.AW(AW), .PW(PW), .WC_CYCLES(WC)) dut (
        .clk(clk), .rst(rst), .spi_cs_n(cs_n), .spi_sck(sck), .spi_mosi(mosi),
        .spi_hold_n(hold_n), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
        .busy(busy), .wreq_valid(wreq_valid), .wreq_is_status(wreq_is_status),
        .wreq_page(wreq_page), .wreq_allow(wreq_allow),
        .prot_status(6'b101000), .stat_wr_valid(stat_wr_valid),
        .stat_wr_data(stat_wr_data)
    );

    int vecs = 0, errs = 0;
    logic mode3 = 1'b0, any_oe = 1'b0, sw_seen = 1'b0;
    logic [7:0] sw_data = '0, junk, st;
    logic [7:0] rbuf [4];
    logic [7:0] wbuf [80];
    int len;

    always @(posedge clk) if (stat_wr_valid) begin sw_seen <= 1'b1; sw_data <= stat_wr_data; end

    task automatic tick(input int n); repeat (n) @(negedge clk); endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic sbit(input logic b, output logic r);
        if (mode3) begin
            sck = 1'b0; mosi = b; tick(HALF);
            sck = 1'b1; r = spi_miso; any_oe |= spi_miso_oe; tick(HALF);
        end else begin
            mosi = b; tick(HALF);
            sck = 1'b1; r = spi_miso; any_oe |= spi_miso_oe; tick(HALF);
            sck = 1'b0;
        end
    endtask

    task automatic sbyte(input logic [7:0] t, output logic [7:0] r);
        for (int i = 7; i >= 0; i--) begin
            logic b;
            sbit(t[i], b);
            r[i] = b;
        end
    endtask

    task automatic cs_lo; sck = mode3; tick(2); cs_n = 1'b0; tick(HALF); any_oe = 1'b0; endtask
    task automatic cs_rise; tick(2); cs_n = 1'b1; endtask
    task automatic cs_hi; cs_rise(); tick(HALF + 4); endtask

    task automatic cmd1(input logic [7:0] op); cs_lo(); sbyte(op, junk); cs_hi(); endtask

    task automatic rdsr(input logic [7:0] op, output logic [7:0] s);
        cs_lo(); sbyte(op, junk); sbyte(8'h00, s); cs_hi();
    endtask

    task automatic rd(input logic [15:0] a, input int n);
        cs_lo(); sbyte(8'h03, junk); sbyte(a[15:8], junk); sbyte(a[7:0], junk);
        for (int i = 0; i < n; i++) sbyte(8'h00, rbuf[i]);
        cs_hi();
    endtask

    task automatic cycle_len(output int n);
        int k = 0;
        while (!busy && k < 40) begin tick(1); k++; end
        n = 0;
        while (busy && n < 5000) begin n++; tick(1); end
        tick(4);
    endtask

    task automatic wr(input logic [15:0] a, input int n, output int clen);
        cs_lo(); sbyte(8'h02, junk); sbyte(a[15:8], junk); sbyte(a[7:0], junk);
        for (int i = 0; i < n; i++) sbyte(wbuf[i], junk);
        cs_rise();
        cycle_len(clen);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errs++;
        $display("FAIL watchdog: got hang expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        tick(5); rst = 1'b0; tick(5);
        chk("R1 oe after reset", spi_miso_oe, 0);
        chk("R1 busy after reset", busy, 0);

        rdsr(8'h05, st);  chk("R2 idle status", st, 8'hA0);
        cmd1(8'h0E);      rdsr(8'h0D, st); chk("R2 set latch, bit3 ignored", st, 8'hA2);
        cmd1(8'h0C);      rdsr(8'h05, st); chk("R2 clear latch", st, 8'hA0);

        // table walk: single-byte write then read back
        for (int v = 0; v < 6; v++) begin
            cmd1(8'h06);
            wbuf[0] = VEC[v][7:0];
            wr(VEC[v][23:8], 1, len);
            chk("R8 cycle length", len, WC);
            rd(VEC[v][23:8], 1);
            chk("R4 readback", rbuf[0], VEC[v][7:0]);
        end
        rdsr(8'h05, st); chk("R8 latch cleared after cycle", st, 8'hA0);
        rd(16'h0005, 1);  chk("R4 upper address bits ignored", rbuf[0], 8'h3C);

        rd(16'h07FF, 2);
        chk("R4 read top", rbuf[0], 8'hC3);
        chk("R4 read wraps to 0", rbuf[1], 8'h5A);

        // page wrap: 66 bytes starting at offset 62 of page 2
        cmd1(8'h06);
        for (int k = 0; k < 66; k++) wbuf[k] = 8'(8'h80 + k);
        wr(16'h00BE, 66, len);
        rd(16'h00BE, 2);
        chk("R7 offset 62 overwritten", rbuf[0], 8'hC0);
        chk("R7 offset 63 overwritten", rbuf[1], 8'hC1);
        rd(16'h0080, 1); chk("R7 wrapped to page start", rbuf[0], 8'h82);
        rd(16'h00BD, 1); chk("R7 offset 61", rbuf[0], 8'hBF);
        rd(16'h00C0, 1); chk("R7 next page untouched", rbuf[0], 8'h33);

        // write without latch
        wbuf[0] = 8'h00;
        wr(16'h0421, 1, len);
        chk("R5 no cycle without latch", len, 0);
        rd(16'h0421, 1); chk("R5 array unchanged", rbuf[0], 8'hE7);

        // chip select rise mid-byte
        cmd1(8'h06);
        cs_lo(); sbyte(8'h02, junk); sbyte(8'h04, junk); sbyte(8'h21, junk); sbyte(8'h99, junk);
        for (int i = 0; i < 4; i++) begin logic b; sbit(1'b1, b); end
        cs_rise(); cycle_len(len);
        chk("R6 mid-byte rise no cycle", len, 0);
        rd(16'h0421, 1); chk("R6 mid-byte rise array unchanged", rbuf[0], 8'hE7);

        // refused by protection unit
        deny_on = 1'b1;
        cmd1(8'h06); wbuf[0] = 8'h22;
        wr(16'h0300, 1, len);
        chk("R6 refused no cycle", len, 0);
        rd(16'h0300, 1); chk("R6 refused array unchanged", rbuf[0], 8'h11);
        deny_on = 1'b0;
        cmd1(8'h04);

        // status write
        cmd1(8'h06);
        cs_lo(); sbyte(8'h01, junk); sbyte(8'h8C, junk); cs_rise(); cycle_len(len);
        chk("R10 status write pulse", sw_seen, 1);
        chk("R10 status write data", sw_data, 8'h8C);
        chk("R10 status write cycle", len, WC);

        // busy behaviour
        cmd1(8'h06);
        cs_lo(); sbyte(8'h02, junk); sbyte(8'h04, junk); sbyte(8'h21, junk); sbyte(8'h5F, junk);
        cs_hi();
        rdsr(8'h05, st); chk("R9 status while busy", st, 8'hFF);
        cs_lo(); sbyte(8'h03, junk); sbyte(8'h00, junk); sbyte(8'h00, junk);
        any_oe = 1'b0; sbyte(8'h00, junk);
        chk("R9 read ignored while busy", any_oe, 0);
        cs_hi();
        chk("R9 still busy", busy, 1);
        cycle_len(len);
        rdsr(8'h05, st); chk("R8 latch cleared", st, 8'hA0);
        rd(16'h0421, 1); chk("R9 committed data", rbuf[0], 8'h5F);

        // unrecognised commands
        cs_lo(); sbyte(8'h07, junk); any_oe = 1'b0;
        sbyte(8'h00, junk); sbyte(8'h00, junk);
        chk("R3 no output after bad command", any_oe, 0);
        cs_hi();
        cs_lo(); sbyte(8'h83, junk); any_oe = 1'b0;
        sbyte(8'h00, junk); sbyte(8'h00, junk); sbyte(8'h00, junk);
        chk("R3 upper nibble set", any_oe, 0);
        cs_hi();
        rd(16'h0000, 1); chk("R3 recovers on next select", rbuf[0], 8'h5A);

        // hold mid-read
        cs_lo(); sbyte(8'h03, junk); sbyte(8'h07, junk); sbyte(8'hFF, junk);
        sbyte(8'h00, rbuf[0]);
        hold_n = 1'b0; tick(HALF);
        chk("R11 output floats in hold", spi_miso_oe, 0);
        for (int i = 0; i < 3; i++) begin sck = 1'b1; mosi = ~mosi; tick(HALF); sck = 1'b0; tick(HALF); end
        hold_n = 1'b1; tick(HALF);
        sbyte(8'h00, rbuf[1]);
        cs_hi();
        chk("R11 byte before hold", rbuf[0], 8'hC3);
        chk("R11 byte after hold", rbuf[1], 8'h5A);

        // mode 3
        mode3 = 1'b1;
        rd(16'hF805, 1); chk("R12 mode 3 read", rbuf[0], 8'h3C);
        rd(16'h07FF, 2); chk("R12 mode 3 wrap", rbuf[1], 8'h5A);
        cmd1(8'h06); rdsr(8'h05, st); chk("R12 mode 3 status", st, 8'hA2);
        wbuf[0] = 8'h6D; wr(16'h0421, 1, len);
        rd(16'h0421, 1); chk("R12 mode 3 write", rbuf[0], 8'h6D);
        mode3 = 1'b0;

        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end
endmodule